// File: doc/BRIEF.md
# Set-Associative Cache Miss Classifier

This block is a tag-only model of a small two-way set-associative cache. A request carries one byte address and a valid strobe. One cycle later the block reports whether that access hit, filled a free way, or pushed out a resident block. Every miss is also sorted into one of three causes.

A miss is compulsory when the block has never been referenced since reset. A miss on a block that was seen before is capacity when a fully associative LRU cache of the same total size would also miss. It is conflict when that equal-size fully associative cache would have hit. No data is stored. Two saturating counters, one for accesses and one for hits, let a caller work out the hit rate.

The block is meant for performance models and checkers that need a per-access miss breakdown alongside a simple tag array. It keeps three structures:
- the set-associative tag array;
- a bit per block address that marks the blocks already referenced;
- a four-entry fully associative shadow with full LRU ordering.

Top module: `cache_miss_sorter`

## Requirements
- R1: The 8-bit byte address splits into a 4-bit tag in bits 7:4, a 1-bit set index in bit 3 and a 3-bit offset in bits 2:0. Two addresses that differ only in bits 2:0 refer to the same block.
- R2: A hit is reported as rsp_hit=1, rsp_evict=0 and rsp_kind=0.
- R3: A miss that finds an invalid way in its set fills that way and reports rsp_hit=0 with rsp_evict=0.
- R4: A miss into a set whose two ways are both valid replaces the least recently used way and reports rsp_evict=1. Both hits and fills make the touched way the most recent one.
- R5: A miss on a block address (bits 7:3) that has not been referenced since reset reports rsp_kind=1 (compulsory). This holds even when the miss evicts a block.
- R6: A miss on a block that was referenced before, and that would also miss in a 4-entry fully associative LRU cache updated on every access, reports rsp_kind=2 (capacity).
- R7: A miss on a block that was referenced before, and that would hit in that fully associative cache, reports rsp_kind=3 (conflict).
- R8: The response appears on the clock edge after a request with rsp_valid=1. When req_valid is low, rsp_valid stays low and no internal state or counter changes.
- R9: access_count counts valid requests and hit_count counts hits. Both are 16 bits wide and stop at 65535 instead of wrapping.
- R10: A synchronous active-high reset invalidates all ways, clears the block history and the shadow, and zeroes both counters and the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 8 | Byte address of the access |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Access hit in the set-associative array |
| rsp_evict | output | 1 | Miss replaced a valid block |
| rsp_kind | output | 2 | 0 none, 1 compulsory, 2 capacity, 3 conflict |
| hit_count | output | 16 | Saturating hit counter |
| access_count | output | 16 | Saturating access counter |

## Verification
A nine-access trace that spreads over both sets checks offset aliasing, LRU victim choice and a capacity miss that comes after a shadow eviction. Three blocks that cycle through one set produce a conflict miss with eviction. Five distinct blocks spread over both sets, followed by a return to the first, separate capacity from conflict. Idle cycles with a changing address, a reset in the middle of a run and a long burst of hits show that an idle strobe has no effect, that reset clears the history, and that both counters saturate.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int ADDR_W   = 8;
  localparam int OFF_W    = 3;
  localparam int IDX_W    = 1;
  localparam int BLK_W    = ADDR_W - OFF_W;
  localparam int TAG_W    = BLK_W - IDX_W;
  localparam int SETS     = 1 << IDX_W;
  localparam int SHADOW_N = 2 * SETS;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_COLD = 2'd1,
    KIND_CAP  = 2'd2,
    KIND_CONF = 2'd3
  } miss_kind_e;

  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W+IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W+IDX_W-1:OFF_W];
  endfunction

  function automatic miss_kind_e sort_miss(input logic hit, input logic seen,
                                           input logic shadow_hit);
    if (hit)             return KIND_NONE;
    else if (!seen)      return KIND_COLD;
    else if (shadow_hit) return KIND_CONF;
    else                 return KIND_CAP;
  endfunction
endpackage

// File: rtl/cms_set_array.sv
module cms_set_array #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [TAG_W-1:0] tag,
  input  logic [IDX_W-1:0] idx,
  output logic             hit,
  output logic             evict
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]             vld0, vld1, lru;
  logic [SETS-1:0][TAG_W-1:0]  tag0, tag1;
  logic m0, m1, fill_way, use_way;

  always_comb begin
    m0 = vld0[idx] && (tag0[idx] == tag);
    m1 = vld1[idx] && (tag1[idx] == tag);
    hit = m0 | m1;
    evict = !hit && vld0[idx] && vld1[idx];
    if (!vld0[idx])      fill_way = 1'b0;
    else if (!vld1[idx]) fill_way = 1'b1;
    else                 fill_way = lru[idx];
    use_way = hit ? m1 : fill_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld0 <= '0;
      vld1 <= '0;
      lru  <= '0;
    end else if (upd) begin
      if (!hit) begin
        if (use_way) begin
          vld1[idx] <= 1'b1;
          tag1[idx] <= tag;
        end else begin
          vld0[idx] <= 1'b1;
          tag0[idx] <= tag;
        end
      end
      lru[idx] <= ~use_way;
    end
  end
endmodule

// File: rtl/cms_history.sv
module cms_history #(
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [BLK_W-1:0] blk,
  output logic             seen
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] ref_bits;

  assign seen = ref_bits[blk];

  always_ff @(posedge clk) begin
    if (rst)      ref_bits <= '0;
    else if (upd) ref_bits[blk] <= 1'b1;
  end
endmodule

// File: rtl/cms_shadow.sv
module cms_shadow #(
  parameter int BLK_W = 5,
  parameter int N     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [BLK_W-1:0] blk,
  output logic             hit
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] OLDEST = AW'(N - 1);

  logic [N-1:0]            vld;
  logic [N-1:0][BLK_W-1:0] btag;
  logic [N-1:0][AW-1:0]    age;
  logic [N-1:0]            hv;
  logic [AW-1:0]           hit_age;
  logic [AW-1:0]           victim;
  logic                    got_free;

  always_comb begin
    hit_age  = '0;
    victim   = '0;
    got_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      hv[i] = vld[i] && (btag[i] == blk);
      if (hv[i]) hit_age = age[i];
    end
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !got_free) begin
        got_free = 1'b1;
        victim   = AW'(i);
      end
    end
    if (!got_free) begin
      for (int i = 0; i < N; i++) begin
        if (age[i] == OLDEST) victim = AW'(i);
      end
    end
    hit = |hv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      age <= '0;
    end else if (upd) begin
      for (int i = 0; i < N; i++) begin
        if (hit) begin
          if (hv[i])                          age[i] <= '0;
          else if (vld[i] && age[i] < hit_age) age[i] <= age[i] + 1'b1;
        end else if (AW'(i) == victim) begin
          vld[i]  <= 1'b1;
          btag[i] <= blk;
          age[i]  <= '0;
        end else if (vld[i]) begin
          age[i] <= age[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cache_miss_sorter.sv
module cache_miss_sorter
  import cms_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_evict,
  output logic [1:0]        rsp_kind,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  access_count
);
  logic       set_hit_w, set_evict_w, seen_w, shadow_hit_w;
  miss_kind_e kind_w;

  cms_set_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_sets (
    .clk(clk), .rst(rst), .upd(req_valid),
    .tag(tag_of(req_addr)), .idx(index_of(req_addr)),
    .hit(set_hit_w), .evict(set_evict_w)
  );

  cms_history #(.BLK_W(BLK_W)) u_hist (
    .clk(clk), .rst(rst), .upd(req_valid),
    .blk(block_of(req_addr)), .seen(seen_w)
  );

  cms_shadow #(.BLK_W(BLK_W), .N(SHADOW_N)) u_shadow (
    .clk(clk), .rst(rst), .upd(req_valid),
    .blk(block_of(req_addr)), .hit(shadow_hit_w)
  );

  assign kind_w = sort_miss(set_hit_w, seen_w, shadow_hit_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_evict    <= 1'b0;
      rsp_kind     <= 2'd0;
      hit_count    <= '0;
      access_count <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && set_hit_w;
      rsp_evict <= req_valid && set_evict_w;
      rsp_kind  <= req_valid ? kind_w : KIND_NONE;
      if (req_valid) begin
        if (access_count != '1) access_count <= access_count + 1'b1;
        if (set_hit_w && hit_count != '1) hit_count <= hit_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cms_checker.sv
module cms_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_evict,
  input logic [1:0]       rsp_kind,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] access_count,
  input logic             set_hit_w,
  input logic             seen_w
);
  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && $stable(access_count) && $stable(hit_count));

  // R2
  hit_clean_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> rsp_kind == 2'd0 && !rsp_evict);

  // R5
  miss_sorted_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> rsp_kind != 2'd0);

  // R5
  hit_needs_seen_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && set_hit_w |-> seen_w);

  // R9
  count_order_chk: assert property (@(posedge clk) disable iff (rst)
    hit_count <= access_count);
endmodule

bind cache_miss_sorter cms_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cache_miss_sorter.sv
module sim_cache_miss_sorter;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [7:0]  req_addr;
  logic        rsp_valid, rsp_hit, rsp_evict;
  logic [1:0]  rsp_kind;
  logic [15:0] hit_count, access_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cache_miss_sorter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_evict(rsp_evict),
    .rsp_kind(rsp_kind), .hit_count(hit_count), .access_count(access_count)
  );

  task automatic check_val(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one access, starting and ending at a falling edge; result sampled there
  task automatic access(input logic [7:0] a, input logic e_hit, input logic e_ev,
                        input int e_kind, input string req);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_val({req, " valid"}, int'(rsp_valid), 1);
    check_val({req, " hit"},   int'(rsp_hit),   int'(e_hit));
    check_val({req, " evict"}, int'(rsp_evict), int'(e_ev));
    check_val({req, " kind"},  int'(rsp_kind),  e_kind);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    req_addr = 8'h00;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // R10: outputs clear after reset
  task automatic t_reset();
    do_reset();
    check_val("R10 rsp_valid", int'(rsp_valid), 0);
    check_val("R10 access_count", int'(access_count), 0);
    check_val("R10 hit_count", int'(hit_count), 0);
    check_val("R10 rsp_kind", int'(rsp_kind), 0);
  endtask

  // R1 R2 R3 R4 R5 R6: mixed trace over both sets
  task automatic t_trace();
    do_reset();
    access(8'h04, 0, 0, 1, "R5 cold 04");
    access(8'h05, 1, 0, 0, "R1 offset alias 05");
    access(8'h68, 0, 0, 1, "R3 free way 68");
    access(8'hC8, 0, 0, 1, "R3 free way C8");
    access(8'h68, 1, 0, 0, "R2 hit 68");
    access(8'hDD, 0, 1, 1, "R5 cold with evict DD");
    access(8'h45, 0, 0, 1, "R3 set0 second way 45");
    access(8'h04, 1, 0, 0, "R4 recency kept 04");
    access(8'hC8, 0, 1, 2, "R6 capacity C8");
    check_val("R9 access_count", int'(access_count), 9);
    check_val("R9 hit_count", int'(hit_count), 3);
  endtask

  // R7 R4: three blocks in one set
  task automatic t_conflict();
    do_reset();
    access(8'h00, 0, 0, 1, "R5 cold 00");
    access(8'h10, 0, 0, 1, "R5 cold 10");
    access(8'h20, 0, 1, 1, "R4 evict LRU 20");
    access(8'h00, 0, 1, 3, "R7 conflict 00");
    access(8'h10, 0, 1, 3, "R7 conflict 10");
  endtask

  // R6: five blocks overflow the shadow
  task automatic t_capacity();
    do_reset();
    access(8'h00, 0, 0, 1, "R5 cold b0");
    access(8'h08, 0, 0, 1, "R5 cold b1");
    access(8'h10, 0, 0, 1, "R5 cold b2");
    access(8'h18, 0, 0, 1, "R5 cold b3");
    access(8'h20, 0, 1, 1, "R5 cold b4");
    access(8'h00, 0, 1, 2, "R6 capacity b0");
  endtask

  // R8 R10: idle strobe ignored, reset clears history
  task automatic t_idle();
    do_reset();
    req_valid = 1'b0;
    req_addr  = 8'h30;
    @(negedge clk);
    req_addr  = 8'h38;
    @(negedge clk);
    check_val("R8 idle rsp_valid", int'(rsp_valid), 0);
    check_val("R8 idle access_count", int'(access_count), 0);
    access(8'h30, 0, 0, 1, "R8 idle left no history 30");
    access(8'h30, 1, 0, 0, "R2 hit 30");
    do_reset();
    access(8'h30, 0, 0, 1, "R10 history cleared 30");
  endtask

  // R9: counters saturate
  task automatic t_saturate();
    do_reset();
    req_valid = 1'b1;
    req_addr  = 8'h00;
    repeat (65540) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check_val("R9 access saturate", int'(access_count), 65535);
    check_val("R9 hit saturate", int'(hit_count), 65535);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_addr = 8'h00;
    @(negedge clk);
    t_reset();
    t_trace();
    t_conflict();
    t_capacity();
    t_idle();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule